// File: doc/BRIEF.md
# Replicated Double-Pumped Multiport Memory

This block is an on-chip memory that accepts one write and seven reads in every cycle of the system clock, with no stalls and no arbitration. It is built from several identical copies of a plain dual-port RAM array. Each copy is clocked by a phase-locked clock at twice the system rate. Over the two fast edges of one system cycle, the two physical ports of a copy give four access slots. Three of the slots serve reads and one carries the write.

Every copy receives the same write in the same system cycle, so all copies always hold the same contents. Each read port is tied to exactly one slot of one copy, so readers never compete for a port. The read ports are flattened into wide vectors. Every read port returns its data with the same fixed latency, aligned to the system clock, and a port whose enable is low keeps its last output.

Top module: `mpram_rep2x`

## Requirements
- R1: In every system cycle the block accepts one write and up to seven reads together, with no stall and no limit on coinciding addresses, including all seven reads naming the same word.
- R2: Data for a read sampled at a system-clock rising edge appears on that port's output after the second following system edge and holds for a whole system cycle.
- R3: A read naming the word written in the same system cycle returns the contents from before that write.
- R4: A write sampled in one cycle is seen by reads sampled in any later cycle, on every read port, until that word is written again.
- R5: A word that has not been written since reset reads as zero.
- R6: When a port's read enable is low, that port's output does not change at the edge where the read's data would have appeared.
- R7: When the write enable is low, the write address and data leave the stored contents unchanged.
- R8: Read ports served by different copies return identical data when they read the same word in the same cycle.
- R9: Read port k is served by copy k/3 in slot k%3. Slots 0 and 1 are served on the fast edge in the middle of the system cycle. Slot 2 and the write (slot 3) are served on the fast edge that coincides with the next system edge. The fast edges alternate strictly between these two halves.
- R10: While reset is asserted, and after its release until the first enabled read returns, all read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all ports are sampled and driven on its rising edge |
| clk2x | input | 1 | Phase-locked clock at twice the system rate; every other rising edge coincides with a system rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| wr_en | input | 1 | Write enable |
| wr_addr | input | log2(DEPTH) | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | N_RD | Read enable, bit k for read port k |
| rd_addr | input | N_RD*log2(DEPTH) | Read addresses; port k uses bits [k*log2(DEPTH) +: log2(DEPTH)] |
| rd_data | output | N_RD*DATA_W | Registered read data; port k uses bits [k*DATA_W +: DATA_W] |

## Verification
The bench uses a 32-word, 16-bit build. It first sweeps reads across all addresses before any write, which shows that unwritten words read as zero. A write sweep follows in which port 0 always reads the word being written while the other ports trail behind it. This pattern separates read-before-write from write-through and shows whether a write reaches every copy. A hammer phase points all seven readers and the writer at one word, so a copy that has fallen out of step or a swapped slot shows up as a mismatch between ports. A long random phase with random enables and idle writes that carry garbage data then probes latency alignment, output hold on disabled ports and the effect of a write enable that is low.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   // access slots one dual-port array offers in a system cycle when double-pumped
   localparam int unsigned SLOTS_PER_COPY = 4;
   // one slot is spent on the shared write, the rest carry reads
   localparam int unsigned RD_SLOTS       = SLOTS_PER_COPY - 1;
   localparam int unsigned WR_SLOT        = RD_SLOTS;

   // which half of the system cycle the current fast edge serves
   typedef enum logic {
      HALF_RD = 1'b0,   // mid-cycle edge: slots 0 and 1 (both ports read)
      HALF_RW = 1'b1    // edge at next system edge: slot 2 read, slot 3 write
   } half_e;

   function automatic int unsigned copies_for(input int unsigned n_rd);
      return (n_rd + RD_SLOTS - 1) / RD_SLOTS;
   endfunction

   function automatic int unsigned copy_of(input int unsigned k);
      return k / RD_SLOTS;
   endfunction

   function automatic int unsigned slot_of(input int unsigned k);
      return k % RD_SLOTS;
   endfunction

   // number of read slots actually used in copy b
   function automatic int unsigned slots_in_copy(input int unsigned n_rd, input int unsigned b);
      int unsigned rem;
      rem = n_rd - b * RD_SLOTS;
      return (rem > RD_SLOTS) ? RD_SLOTS : rem;
   endfunction

endpackage

// File: rtl/mpr_phase_det.sv
module mpr_phase_det
   import mpr_pkg::*;
(
   input  logic  clk,
   input  logic  clk2x,
   input  logic  rst_n,
   output half_e half,
   output logic  lock
);

   logic       sys_tog;
   logic       fast_tog;
   logic [1:0] warm_cnt;

   // toggles once per system cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sys_tog <= 1'b0;
      else        sys_tog <= ~sys_tog;
   end

   // fast-domain copy: differs from sys_tog only on the mid-cycle fast edge
   always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
         fast_tog <= 1'b0;
         warm_cnt <= 2'd0;
      end else begin
         fast_tog <= sys_tog;
         if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
      end
   end

   assign half = (sys_tog != fast_tog) ? HALF_RD : HALF_RW;
   assign lock = (warm_cnt == 2'd3);

   // R9
   half_alt_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !lock)
      half != $past(half));

endmodule

// File: rtl/mpr_fill_map.sv
module mpr_fill_map #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned N_Q   = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          set_en,
   input  logic [$clog2(DEPTH)-1:0]      set_addr,
   input  logic [N_Q*$clog2(DEPTH)-1:0]  q_addr,
   output logic [N_Q-1:0]                q_hit
);

   localparam int unsigned AW = $clog2(DEPTH);

   logic [DEPTH-1:0] filled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      filled <= '0;
      else if (set_en) filled[set_addr] <= 1'b1;
   end

   always_comb begin
      for (int k = 0; k < int'(N_Q); k++) q_hit[k] = filled[q_addr[k*AW +: AW]];
   end

   // R5
   fill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filled & $past(filled)) == $past(filled));

   // R4
   fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_en) |-> filled[$past(set_addr)]);

endmodule

// File: rtl/mpr_copy.sv
module mpr_copy
   import mpr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned N_USE  = 3
) (
   input  logic                            clk2x,
   input  logic                            rst_n,
   input  half_e                           half,
   input  logic                            lock,
   input  logic [N_USE-1:0]                rd_en,
   input  logic [N_USE*$clog2(DEPTH)-1:0]  rd_addr,
   input  logic                            wr_en,
   input  logic [$clog2(DEPTH)-1:0]        wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   output logic [N_USE*DATA_W-1:0]         rd_q
);

   localparam int unsigned AW   = $clog2(DEPTH);
   localparam int unsigned N_PA = (N_USE < 2) ? N_USE : 2;  // slots served mid-cycle

   if (N_USE < 1 || N_USE > RD_SLOTS) begin : g_bad_use
      $error("mpr_copy: N_USE out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // slot 3: write on port B at the fast edge that closes the system cycle
   always_ff @(posedge clk2x) begin
      if (half == HALF_RW && wr_en) mem[wr_addr] <= wr_data;
   end

   // slots 0/1: ports A and B read mid-cycle; hold stage copies them at the closing edge
   for (genvar s = 0; s < int'(N_PA); s++) begin : g_pair
      logic [DATA_W-1:0] port_q;
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk2x or negedge rst_n) begin
         if (!rst_n) begin
            port_q <= '0;
            hold_q <= '0;
         end else if (half == HALF_RD) begin
            if (rd_en[s]) port_q <= mem[rd_addr[s*AW +: AW]];
         end else begin
            hold_q <= port_q;
         end
      end
      assign rd_q[s*DATA_W +: DATA_W] = hold_q;
   end

   // slot 2: port A reads at the closing edge, alongside the write on port B
   if (N_USE == RD_SLOTS) begin : g_late
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk2x or negedge rst_n) begin
         if (!rst_n)                              hold_q <= '0;
         else if (half == HALF_RW && rd_en[2])    hold_q <= mem[rd_addr[2*AW +: AW]];
      end
      assign rd_q[2*DATA_W +: DATA_W] = hold_q;
   end

   // R9
   slot_hold_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !lock)
      (half == HALF_RW) |-> ($stable(rd_en) && $stable(rd_addr) && $stable(wr_en)
                             && $stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/mpram_rep2x.sv
module mpram_rep2x
   import mpr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned N_RD   = 7
) (
   input  logic                           clk,
   input  logic                           clk2x,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [$clog2(DEPTH)-1:0]       wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [N_RD-1:0]                rd_en,
   input  logic [N_RD*$clog2(DEPTH)-1:0]  rd_addr,
   output logic [N_RD*DATA_W-1:0]         rd_data
);

   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned N_COPY = copies_for(N_RD);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mpram_rep2x: DEPTH must be a power of two");
   end
   if (N_RD < 1) begin : g_bad_nrd
      $error("mpram_rep2x: at least one read port required");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("mpram_rep2x: DATA_W must be positive");
   end

   // ---------------- stage 1: capture requests ----------------
   logic                   wr_en_c;
   logic [AW-1:0]          wr_addr_c;
   logic [DATA_W-1:0]      wr_data_c;
   logic [N_RD-1:0]        rd_en_c;
   logic [N_RD*AW-1:0]     rd_addr_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_c   <= 1'b0;
         wr_addr_c <= '0;
         wr_data_c <= '0;
         rd_en_c   <= '0;
         rd_addr_c <= '0;
      end else begin
         wr_en_c   <= wr_en;
         wr_addr_c <= wr_addr;
         wr_data_c <= wr_data;
         rd_en_c   <= rd_en;
         rd_addr_c <= rd_addr;
      end
   end

   // cycles since reset, for assertions that look back
   logic [2:0] up_cnt;
   logic       up_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              up_cnt <= 3'd0;
      else if (up_cnt != 3'd4) up_cnt <= up_cnt + 3'd1;
   end
   assign up_ok = (up_cnt == 3'd4);

   // ---------------- fast-clock phase ----------------
   half_e half;
   logic  ph_lock;

   mpr_phase_det u_phase (
      .clk   (clk),
      .clk2x (clk2x),
      .rst_n (rst_n),
      .half  (half),
      .lock  (ph_lock)
   );

   // ---------------- replicated copies ----------------
   for (genvar b = 0; b < int'(N_COPY); b++) begin : g_copy
      localparam int unsigned NU = slots_in_copy(N_RD, b);
      logic [NU-1:0]        s_en;
      logic [NU*AW-1:0]     s_addr;
      logic [NU*DATA_W-1:0] s_q;

      for (genvar s = 0; s < int'(NU); s++) begin : g_slot
         localparam int unsigned K = b * RD_SLOTS + s;
         assign s_en[s]             = rd_en_c[K];
         assign s_addr[s*AW +: AW]  = rd_addr_c[K*AW +: AW];
      end

      mpr_copy #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH),
         .N_USE  (NU)
      ) u_copy (
         .clk2x   (clk2x),
         .rst_n   (rst_n),
         .half    (half),
         .lock    (ph_lock),
         .rd_en   (s_en),
         .rd_addr (s_addr),
         .wr_en   (wr_en_c),
         .wr_addr (wr_addr_c),
         .wr_data (wr_data_c),
         .rd_q    (s_q)
      );
   end

   // ---------------- stage 2: written-since-reset lookup ----------------
   logic [N_RD-1:0] hit;
   logic [N_RD-1:0] en2;
   logic [N_RD-1:0] vld2;

   mpr_fill_map #(
      .DEPTH (DEPTH),
      .N_Q   (N_RD)
   ) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (wr_en_c),
      .set_addr (wr_addr_c),
      .q_addr   (rd_addr_c),
      .q_hit    (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en2  <= '0;
         vld2 <= '0;
      end else begin
         en2  <= rd_en_c;
         vld2 <= hit;
      end
   end

   // ---------------- stage 3: output registers ----------------
   for (genvar k = 0; k < int'(N_RD); k++) begin : g_port
      localparam int unsigned B = copy_of(k);
      localparam int unsigned S = slot_of(k);
      logic [DATA_W-1:0] oq;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      oq <= '0;
         else if (en2[k]) oq <= vld2[k] ? g_copy[B].s_q[S*DATA_W +: DATA_W] : '0;
      end
      assign rd_data[k*DATA_W +: DATA_W] = oq;

      // R6
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_ok)
         !$past(rd_en[k], 3) |-> $stable(rd_data[k*DATA_W +: DATA_W]));
   end

   // ports in different copies reading one word together must agree
   for (genvar k = 0; k + RD_SLOTS < N_RD; k++) begin : g_pair_chk
      // R8
      replica_match_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_ok)
         ($past(rd_en[k], 3) && $past(rd_en[k+RD_SLOTS], 3)
          && ($past(rd_addr[k*AW +: AW], 3) == $past(rd_addr[(k+RD_SLOTS)*AW +: AW], 3)))
         |-> (rd_data[k*DATA_W +: DATA_W] == rd_data[(k+RD_SLOTS)*DATA_W +: DATA_W]));
   end

endmodule

// File: tb/mpram_rep2x_tb.sv
`timescale 1ns/1ps
module mpram_rep2x_tb;

   localparam int DW    = 16;
   localparam int DEPTH = 32;
   localparam int AW    = 5;
   localparam int NRD   = 7;

   logic              clk = 1'b0;
   logic              clk2x = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [DW-1:0]     wr_data = '0;
   logic [NRD-1:0]    rd_en = '0;
   logic [NRD*AW-1:0] rd_addr = '0;
   logic [NRD*DW-1:0] rd_data;

   mpram_rep2x #(.DATA_W(DW), .DEPTH(DEPTH), .N_RD(NRD)) u_dut (
      .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // 125 MHz system clock, phase-locked 250 MHz fast clock
   initial begin
      forever begin
         clk = 1'b1; clk2x = 1'b1;
         #2 clk2x = 1'b0;
         #2 clk = 1'b0; clk2x = 1'b1;
         #2 clk2x = 1'b0;
         #2;
      end
   end

   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] p_dat [3][NRD];
   logic          p_en  [3][NRD];
   string         p_tag [3];
   logic [DW-1:0] cur   [NRD];
   logic [AW-1:0] ra    [NRD];
   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   function automatic logic [DW-1:0] pat(input int a, input int s);
      return DW'((a + 1) * 1237 + s * 4099 + 7);
   endfunction

   task automatic check_port(input int k, input string tag);
      n_chk++;
      if (rd_data[k*DW +: DW] !== cur[k]) begin
         n_bad++;
         $display("FAIL %s port %0d step %0d: got %h expected %h",
                  tag, k, cyc, rd_data[k*DW +: DW], cur[k]);
      end
   endtask

   // one system cycle: retire and check the request from three steps back, then apply a new one
   task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [NRD-1:0] re, input string tag);
      int slot;
      @(posedge clk); #1;
      slot = cyc % 3;
      for (int k = 0; k < NRD; k++) begin
         if (p_en[slot][k]) cur[k] = p_dat[slot][k];
         check_port(k, p_tag[slot]);
      end
      for (int k = 0; k < NRD; k++) begin
         p_en[slot][k]  = re[k];
         p_dat[slot][k] = ref_mem[ra[k]];   // read-before-write model
      end
      p_tag[slot] = tag;
      if (we) ref_mem[wa] = wd;
      wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re;
      for (int k = 0; k < NRD; k++) rd_addr[k*AW +: AW] = ra[k];
      cyc++;
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog R2: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
      for (int s = 0; s < 3; s++) begin
         p_tag[s] = "R10";
         for (int k = 0; k < NRD; k++) begin p_en[s][k] = 1'b0; p_dat[s][k] = '0; end
      end
      for (int k = 0; k < NRD; k++) begin cur[k] = '0; ra[k] = '0; end

      repeat (3) @(posedge clk);
      #1;
      for (int k = 0; k < NRD; k++) check_port(k, "R10");  // under reset
      rst_n = 1'b1;
      @(posedge clk); #1;
      for (int k = 0; k < NRD; k++) check_port(k, "R10");  // just after release

      // unwritten words read zero on every port; idle write carries garbage
      for (int a = 0; a < DEPTH; a++) begin
         for (int k = 0; k < NRD; k++) ra[k] = AW'((a + k * 5) % DEPTH);
         step(1'b0, AW'(a), pat(a, 9), '1, "R5/R9/R7");
      end

      // write sweep: port 0 reads the word being written, others trail it
      for (int a = 0; a < DEPTH; a++) begin
         for (int k = 0; k < NRD; k++) ra[k] = AW'((a - k + DEPTH) % DEPTH);
         step(1'b1, AW'(a), pat(a, 1), '1, "R3/R4");
      end

      // all seven readers and the writer on one word
      for (int i = 0; i < 12; i++) begin
         for (int k = 0; k < NRD; k++) ra[k] = AW'(5);
         step(1'b1, AW'(5), pat(i, 2), '1, "R1/R8/R3");
      end

      // write enable low with garbage, then read back
      for (int i = 0; i < 4; i++) begin
         for (int k = 0; k < NRD; k++) ra[k] = AW'(7);
         step(1'b0, AW'(7), 16'hDEAD, '1, "R7");
      end

      // random mix: addresses, enables, writes
      for (int i = 0; i < 600; i++) begin
         logic [NRD-1:0] re_r;
         logic           we_r;
         for (int k = 0; k < NRD; k++) ra[k] = AW'($urandom % DEPTH);
         if (i % 50 < 5) begin
            for (int k = 1; k < NRD; k++) ra[k] = ra[0];
         end
         re_r = NRD'($urandom);
         we_r = 1'($urandom);
         step(we_r, AW'($urandom % DEPTH), DW'($urandom), re_r, "R2/R6/R1");
      end

      // drain with reads disabled: outputs must hold
      for (int i = 0; i < 4; i++) step(1'b0, '0, '0, '0, "R6");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule